// File: doc/BRIEF.md
# Chained DMA channel controller

A single-channel DMA engine that moves a programmed number of bytes between a peripheral and memory. Software sees three 32-bit registers: a control/status word, an address word and a count word. It stages the next transfer by writing a byte count and then a start address. The engine lifts that staged pair into an active transfer as soon as the active slot is free. It then walks memory in bursts of 1, 4, 8 or 16 words through a request/acknowledge port. Each acknowledged beat advances the address by one word.

A second pair can be staged while a transfer runs. When chaining is enabled, the engine switches to that pair in the same cycle the active transfer completes, so transfers follow back to back with only the normal one-cycle burst gap. Pending flags for transfer completion, device requests and bus errors are cleared by writing one to them, and they combine into a single interrupt line. A software reset aborts the channel at once but keeps an outstanding bus cycle alive until it is acknowledged, and it reports that drain in the status word.

Top module: `chain_dma_ch`

## Requirements
- R1: After `rst_n` is released, all three registers read 0, `irq` is 0 and `mem_req` is 0.
- R2: A count write (offset 0x8) followed by an address write (offset 0x4) stages a pair and sets next-loaded (status bit 27). Both writes are refused while bit 27 is already set or while DMA enable (bit 9) is clear.
- R3: When no transfer is active, a staged pair with bit 9 set moves to active in one cycle: active-loaded (bit 26) sets and bit 27 clears. The address register then reads the current address and the count register reads the remaining bytes.
- R4: The burst field in bits 19:18 gives the beats per burst: 2'b10 gives 1, 2'b00 gives 4, 2'b01 gives 8 and 2'b11 gives 16. Bursts are separated by exactly one cycle with `mem_req` low, and the last burst is cut short at the end of the count. `mem_req` and `mem_addr` hold until `mem_ack`.
- R5: Each acknowledged beat adds 4 to the address. When count enable (bit 13) is set, each beat also takes 4 from the count, and a beat that starts with 4 or fewer bytes left brings the count to 0. With bit 13 clear, the count does not change.
- R6: Reaching a count of 0 sets terminal count (bit 14). It also sets interrupt pending (bit 0) unless the terminal-count interrupt disable (bit 23) is set.
- R7: When a transfer completes with chaining (bit 24) set and a pair staged, the staged pair becomes active in that same cycle and bit 26 stays set. Otherwise bit 26 clears.
- R8: Status bits 0, 1 and 14 are cleared by writing 1 to them in a control write. Writing 0 leaves them unchanged, and a hardware set in the same cycle wins over the clear.
- R9: A beat acknowledged with `mem_err` high sets error pending (bit 1) and abandons the active transfer (bit 26 clears).
- R10: A `dev_req` pulse sets bit 0 and leaves bit 14 unchanged.
- R11: `irq` equals interrupt enable (bit 4) AND (bit 0 OR bit 1).
- R12: Writing 1 to bit 7 clears all control bits, all pending bits and both pairs. If a memory cycle is outstanding, `mem_req` stays high until its acknowledge, with draining (bit 2) and cycle-pending (bit 10) reading 1. No new cycle starts.
- R13: `mem_wr` follows the direction bit (bit 8, 1 = write to memory). DMA-active (bit 25) reads 1 while a burst is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | 4 | Register byte offset (0x0, 0x4, 0x8) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_off` |
| dev_req | input | 1 | Peripheral interrupt request pulse |
| mem_req | output | 1 | Memory cycle request |
| mem_wr | output | 1 | Direction of the memory cycle, 1 = write |
| mem_addr | output | ADDR_W | Memory word address of the current beat |
| mem_ack | input | 1 | Memory cycle acknowledge; one beat per acknowledged cycle |
| mem_err | input | 1 | Error on the acknowledged cycle |
| irq | output | 1 | Interrupt request |

## Verification
A wrong beat counter shows up within one burst as a request run of the wrong length, or as a missing one-cycle gap on `mem_req`. A wrong address or count update shows up on the next beat's `mem_addr`, and in the residue read after the transfer completes. Errors in the staging and chaining logic show up as missing or repeated address runs, or as a next-loaded bit that is wrong right after the refused write. Errors in the pending flags and the drain show up in the status word and on `irq` in the cycle after the event.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
   localparam int unsigned B_IPEND = 0;
   localparam int unsigned B_EPEND = 1;
   localparam int unsigned B_DRAIN = 2;
   localparam int unsigned B_IEN   = 4;
   localparam int unsigned B_SRST  = 7;
   localparam int unsigned B_DIR   = 8;
   localparam int unsigned B_EN    = 9;
   localparam int unsigned B_CYC   = 10;
   localparam int unsigned B_CNTEN = 13;
   localparam int unsigned B_TC    = 14;
   localparam int unsigned B_BLO   = 18;
   localparam int unsigned B_TCOFF = 23;
   localparam int unsigned B_CHAIN = 24;
   localparam int unsigned B_BUSY  = 25;
   localparam int unsigned B_ACT   = 26;
   localparam int unsigned B_NXT   = 27;

   localparam logic [1:0] IDX_CSR = 2'd0;
   localparam logic [1:0] IDX_ADR = 2'd1;
   localparam logic [1:0] IDX_CNT = 2'd2;

   typedef struct packed {
      logic       int_en;
      logic       dir;
      logic       dma_en;
      logic       cnt_en;
      logic       tci_dis;
      logic       chain_en;
      logic [1:0] burst;
   } ctl_t;

   typedef enum logic [1:0] {S_IDLE, S_XFER, S_DRAIN} seq_st_t;

   function automatic logic [4:0] beats_of(input logic [1:0] code);
      case (code)
         2'b10:   beats_of = 5'd1;
         2'b00:   beats_of = 5'd4;
         2'b01:   beats_of = 5'd8;
         default: beats_of = 5'd16;
      endcase
   endfunction
endpackage

// File: rtl/cdma_seq.sv
module cdma_seq
   import cdma_pkg::*;
#(
   parameter int unsigned LEN_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort,
   input  logic             go,
   input  logic             en,
   input  logic             last,
   input  logic [LEN_W-1:0] len,
   input  logic             mem_ack,
   input  logic             mem_err,
   output logic             mem_req,
   output logic             beat,
   output logic             busy,
   output logic             draining,
   output logic             idle,
   output logic [LEN_W-1:0] len_q
);
   seq_st_t          st;
   logic [LEN_W-1:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         idx   <= '0;
         len_q <= LEN_W'(1);
      end else begin
         case (st)
            S_IDLE: if (go && !abort) begin
               st    <= S_XFER;
               len_q <= len;
               idx   <= '0;
            end
            S_XFER: begin
               if (abort) st <= mem_ack ? S_IDLE : S_DRAIN;
               else if (mem_ack) begin
                  if (mem_err || last || !en || idx == len_q - LEN_W'(1)) st <= S_IDLE;
                  else idx <= idx + LEN_W'(1);
               end
            end
            S_DRAIN: if (mem_ack) st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign mem_req  = (st == S_XFER) || (st == S_DRAIN);
   assign beat     = (st == S_XFER) && mem_ack && !abort;
   assign busy     = (st == S_XFER);
   assign draining = (st == S_DRAIN);
   assign idle     = (st == S_IDLE);
endmodule

// File: rtl/cdma_irq.sv
module cdma_irq #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic w1c_we,
   input  logic w1c_ip,
   input  logic w1c_ep,
   input  logic w1c_tc,
   input  logic set_tc,
   input  logic set_dev,
   input  logic set_err,
   input  logic tci_dis,
   input  logic int_en,
   output logic int_pend,
   output logic err_pend,
   output logic tc,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_pend <= 1'b0;
         err_pend <= 1'b0;
         tc       <= 1'b0;
      end else if (clr) begin
         int_pend <= 1'b0;
         err_pend <= 1'b0;
         tc       <= 1'b0;
      end else begin
         int_pend <= (int_pend & ~(w1c_we & w1c_ip)) | (set_tc & ~tci_dis) | set_dev;
         err_pend <= (err_pend & ~(w1c_we & w1c_ep)) | set_err;
         tc       <= (tc & ~(w1c_we & w1c_tc)) | set_tc;
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= int_en & (int_pend | err_pend);
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = int_en & (int_pend | err_pend);
      end
   endgenerate
endmodule

// File: rtl/chain_dma_ch.sv
module chain_dma_ch
   import cdma_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned CNT_W   = 24,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [3:0]        reg_off,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              dev_req,
   output logic              mem_req,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic              mem_err,
   output logic              irq
);
   localparam int unsigned LEN_W = 5;
   localparam logic [ADDR_W-1:0] A_STEP = ADDR_W'(4);
   localparam logic [CNT_W-1:0]  C_STEP = CNT_W'(4);

   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie in 8..32");
      end
      if (CNT_W < 3 || CNT_W > ADDR_W) begin : g_bad_cnt
         $error("CNT_W must lie in 3..ADDR_W");
      end
   endgenerate

   ctl_t              ctl;
   logic [ADDR_W-1:0] nxt_addr, act_addr;
   logic [CNT_W-1:0]  nxt_cnt, act_cnt, cnt_next;
   logic              nxt_vld, act_vld;
   logic              wr_csr, wr_adr, wr_cnt, soft_rst, stage_ok;
   logic              rem_last, beat, busy, draining, seq_idle, done, go;
   logic [LEN_W-1:0]  seq_len;
   logic              int_pend, err_pend, tc;

   assign wr_csr   = reg_wr && (reg_off[3:2] == IDX_CSR);
   assign wr_adr   = reg_wr && (reg_off[3:2] == IDX_ADR);
   assign wr_cnt   = reg_wr && (reg_off[3:2] == IDX_CNT);
   assign soft_rst = wr_csr && reg_wdata[B_SRST];
   assign stage_ok = ctl.dma_en && !nxt_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctl <= '0;
      else if (soft_rst) ctl <= '0;
      else if (wr_csr) begin
         ctl.int_en   <= reg_wdata[B_IEN];
         ctl.dir      <= reg_wdata[B_DIR];
         ctl.dma_en   <= reg_wdata[B_EN];
         ctl.cnt_en   <= reg_wdata[B_CNTEN];
         ctl.tci_dis  <= reg_wdata[B_TCOFF];
         ctl.chain_en <= reg_wdata[B_CHAIN];
         ctl.burst    <= reg_wdata[B_BLO+1:B_BLO];
      end
   end

   assign rem_last = act_cnt <= C_STEP;
   assign cnt_next = rem_last ? '0 : act_cnt - C_STEP;
   assign done     = (beat && !mem_err && ctl.cnt_en && rem_last) ||
                     (act_vld && seq_idle && act_cnt == '0);
   assign go       = act_vld && ctl.dma_en && act_cnt != '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nxt_addr <= '0;
         nxt_cnt  <= '0;
         nxt_vld  <= 1'b0;
         act_addr <= '0;
         act_cnt  <= '0;
         act_vld  <= 1'b0;
      end else if (soft_rst) begin
         nxt_vld <= 1'b0;
         act_vld <= 1'b0;
      end else begin
         if (wr_cnt && stage_ok) nxt_cnt <= reg_wdata[CNT_W-1:0];
         if (wr_adr && stage_ok) begin
            nxt_addr <= reg_wdata[ADDR_W-1:0];
            nxt_vld  <= 1'b1;
         end
         if (beat) begin
            if (mem_err) act_vld <= 1'b0;
            else begin
               act_addr <= act_addr + A_STEP;
               if (ctl.cnt_en) act_cnt <= cnt_next;
            end
         end
         if (done) begin
            if (ctl.chain_en && nxt_vld) begin
               act_addr <= nxt_addr;
               act_cnt  <= nxt_cnt;
               nxt_vld  <= 1'b0;
            end else begin
               act_vld <= 1'b0;
            end
         end else if (!act_vld && nxt_vld && ctl.dma_en) begin
            act_addr <= nxt_addr;
            act_cnt  <= nxt_cnt;
            act_vld  <= 1'b1;
            nxt_vld  <= 1'b0;
         end
      end
   end

   cdma_seq #(.LEN_W(LEN_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .abort(soft_rst), .go(go), .en(ctl.dma_en),
      .last(ctl.cnt_en && rem_last), .len(beats_of(ctl.burst)),
      .mem_ack(mem_ack), .mem_err(mem_err), .mem_req(mem_req), .beat(beat),
      .busy(busy), .draining(draining), .idle(seq_idle), .len_q(seq_len)
   );

   cdma_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst), .w1c_we(wr_csr),
      .w1c_ip(reg_wdata[B_IPEND]), .w1c_ep(reg_wdata[B_EPEND]), .w1c_tc(reg_wdata[B_TC]),
      .set_tc(done), .set_dev(dev_req), .set_err(beat && mem_err),
      .tci_dis(ctl.tci_dis), .int_en(ctl.int_en),
      .int_pend(int_pend), .err_pend(err_pend), .tc(tc), .irq(irq)
   );

   assign mem_addr = act_addr;
   assign mem_wr   = ctl.dir;

   always_comb begin
      reg_rdata = '0;
      case (reg_off[3:2])
         IDX_CSR: begin
            reg_rdata[B_IPEND]         = int_pend;
            reg_rdata[B_EPEND]         = err_pend;
            reg_rdata[B_DRAIN]         = draining;
            reg_rdata[B_IEN]           = ctl.int_en;
            reg_rdata[B_DIR]           = ctl.dir;
            reg_rdata[B_EN]            = ctl.dma_en;
            reg_rdata[B_CYC]           = mem_req;
            reg_rdata[B_CNTEN]         = ctl.cnt_en;
            reg_rdata[B_TC]            = tc;
            reg_rdata[B_BLO+1:B_BLO]   = ctl.burst;
            reg_rdata[B_TCOFF]         = ctl.tci_dis;
            reg_rdata[B_CHAIN]         = ctl.chain_en;
            reg_rdata[B_BUSY]          = busy;
            reg_rdata[B_ACT]           = act_vld;
            reg_rdata[B_NXT]           = nxt_vld;
         end
         IDX_ADR: reg_rdata[ADDR_W-1:0] = act_addr;
         IDX_CNT: reg_rdata[CNT_W-1:0]  = act_cnt;
         default: reg_rdata = '0;
      endcase
   end

   logic unused_bits;
   assign unused_bits = ^{reg_off[1:0], reg_wdata};
endmodule

// File: rtl/chain_dma_ch_chk.sv
module chain_dma_ch_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              nxt_vld,
   input logic              act_vld,
   input logic [ADDR_W-1:0] nxt_addr,
   input logic              irq,
   input logic              int_en,
   input logic              draining,
   input logic [4:0]        seq_len
);
   logic [5:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_cnt <= '0;
      else if (!mem_req) run_cnt <= '0;
      else if (mem_ack)  run_cnt <= run_cnt + 6'd1;
   end

   // R4: no burst carries more beats than its latched length
   always_comb begin
      if (rst_n) assert_burst_len_R4: assert (run_cnt <= {1'b0, seq_len});
   end

   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

   assert_stage_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      nxt_vld |=> !nxt_vld || $stable(nxt_addr));

   assert_promote_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_vld) |-> $past(nxt_vld));

   assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (int_en || $past(int_en)));

   assert_drain_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
      draining |-> mem_req);
endmodule

bind chain_dma_ch chain_dma_ch_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
   .nxt_vld(nxt_vld), .act_vld(act_vld), .nxt_addr(nxt_addr), .irq(irq),
   .int_en(ctl.int_en), .draining(draining), .seq_len(seq_len)
);

// File: tb/chain_dma_ch_tb.sv
module chain_dma_ch_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_off = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        dev_req = 1'b0;
   logic        mem_req, mem_wr, irq;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic        mem_err = 1'b0;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   chain_dma_ch u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .dev_req(dev_req), .mem_req(mem_req), .mem_wr(mem_wr),
      .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq)
   );

   // memory responder
   bit ack_en = 1'b1;
   bit err_mode = 1'b0;
   always @(posedge clk) begin
      mem_ack <= ack_en && mem_req && !mem_ack;
      mem_err <= ack_en && mem_req && !mem_ack && err_mode;
   end

   // beat monitor
   int          beats, cur_run, nruns, addr_bad, wr_bad;
   int          runs [0:63];
   logic [31:0] exp_list [0:63];
   bit          chk_addr;
   bit          exp_wr;
   always @(negedge clk) begin
      if (mem_req && mem_ack) begin
         if (chk_addr && beats < 64 && mem_addr != exp_list[beats]) addr_bad++;
         if (mem_wr != exp_wr) wr_bad++;
         beats++;
         cur_run++;
      end
      if (!mem_req && cur_run > 0) begin
         if (nruns < 64) runs[nruns] = cur_run;
         nruns++;
         cur_run = 0;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired got=%0d exp=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] off, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_off = off; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] off, output logic [31:0] d);
      reg_off = off;
      #1 d = reg_rdata;
   endtask

   task automatic mon_clear(input logic [31:0] base, input int n, input bit dir);
      beats = 0; cur_run = 0; nruns = 0; addr_bad = 0; wr_bad = 0;
      chk_addr = 1'b1; exp_wr = dir;
      for (int i = 0; i < 64; i++) exp_list[i] = (i < n) ? base + 32'(4 * i) : 32'hffff_ffff;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         rd(4'h0, s);
         if (s[27:25] == 3'b000 && !mem_req && cur_run == 0) break;
      end
      @(negedge clk);
   endtask

   function automatic int blen(input int code);
      case (code)
         2: return 1;
         0: return 4;
         1: return 8;
         default: return 16;
      endcase
   endfunction

   localparam logic [31:0] CTL = (32'd1 << 9) | (32'd1 << 13) | (32'd1 << 4);
   localparam logic [31:0] W1C = 32'h0000_4003;

   initial begin
      logic [31:0] s, v;
      // R1: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(4'h0, s); chk(s == 0, "R1 csr", s, 0);
      rd(4'h4, v); chk(v == 0, "R1 addr", v, 0);
      rd(4'h8, v); chk(v == 0, "R1 count", v, 0);
      chk(irq == 0 && mem_req == 0, "R1 irq/req", {irq, mem_req}, 0);

      // R2: staging refused while DMA enable clear
      wr(4'h0, CTL & ~(32'd1 << 9));
      mon_clear(32'h100, 0, 0);
      wr(4'h8, 32'd16); wr(4'h4, 32'h100);
      rd(4'h0, s); chk(s[27] == 0, "R2 refused while disabled", s[27], 0);
      repeat (8) @(negedge clk);
      chk(beats == 0, "R2 no beats while disabled", beats, 0);

      // R4 R5 R6: sweep burst codes and word counts
      for (int code = 0; code < 4; code++) begin
         for (int n = 1; n <= 20; n++) begin
            int b, nr, bytes;
            logic [31:0] base;
            bit ok_runs;
            b = blen(code);
            base = 32'h4000 + 32'(n * 256);
            bytes = 4 * n - ((n % 3 == 0) ? 2 : 0);
            mon_clear(base, n, 0);
            wr(4'h0, CTL | (32'(code) << 18) | W1C);
            wr(4'h8, 32'(bytes));
            wr(4'h4, base);
            wait_idle();
            nr = (n + b - 1) / b;
            ok_runs = (nruns == nr);
            for (int k = 0; k < nr && k < 64; k++)
               if (runs[k] != ((k == nr - 1) ? n - b * (nr - 1) : b)) ok_runs = 0;
            chk(ok_runs, "R4 burst run lengths and gaps", nruns, nr);
            chk(beats == n && addr_bad == 0, "R5 beat addresses", {beats, addr_bad}, {n, 0});
            rd(4'h8, v); chk(v == 0, "R5 residue zero", v, 0);
            rd(4'h4, v); chk(v == base + 32'(4 * n), "R5 final address", v, base + 32'(4 * n));
            rd(4'h0, s); chk(s[14] && s[0] && irq, "R6 tc and int pend", {s[14], s[0], irq}, 3'b111);
         end
      end

      // R8: writing zeros keeps pending, writing ones clears
      wr(4'h0, CTL);
      rd(4'h0, s); chk(s[14] && s[0], "R8 zero write keeps", {s[14], s[0]}, 2'b11);
      wr(4'h0, CTL | W1C);
      rd(4'h0, s); chk(s[14] == 0 && s[0] == 0 && irq == 0, "R8 one write clears", {s[14], s[0], irq}, 0);

      // R3: promotion and residue read
      mon_clear(32'h800, 3, 0);
      wr(4'h8, 32'd12); wr(4'h4, 32'h800);
      for (int i = 0; i < 20; i++) begin
         rd(4'h0, s);
         if (s[26]) break;
         @(negedge clk);
      end
      chk(s[26] && !s[27], "R3 promoted", s[27:26], 2'b01);
      rd(4'h8, v); chk(v == 12, "R3 count residue at start", v, 12);
      rd(4'h4, v); chk(v == 32'h800, "R3 address at start", v, 32'h800);
      wait_idle();
      wr(4'h0, CTL | W1C);

      // R7 R2: chaining with a refused third pair
      mon_clear(32'h1000, 11, 0);
      for (int i = 0; i < 5; i++) exp_list[6 + i] = 32'h2000 + 32'(4 * i);
      wr(4'h0, CTL | (32'd1 << 24));
      wr(4'h8, 32'd24); wr(4'h4, 32'h1000);
      for (int i = 0; i < 20; i++) begin
         rd(4'h0, s);
         if (s[26] && !s[27]) break;
         @(negedge clk);
      end
      wr(4'h8, 32'd20); wr(4'h4, 32'h2000);
      rd(4'h0, s); chk(s[27] && s[26], "R2 second pair staged", s[27:26], 2'b11);
      wr(4'h8, 32'd4); wr(4'h4, 32'h3000);
      rd(4'h0, s); chk(s[27], "R2 third pair refused", s[27], 1);
      wait_idle();
      chk(beats == 11 && addr_bad == 0, "R7 chained addresses", {beats, addr_bad}, {11, 0});
      chk(nruns == 4 && runs[0] == 4 && runs[1] == 2 && runs[2] == 4 && runs[3] == 1,
          "R7 chained runs", nruns, 4);
      rd(4'h0, s); chk(s[26] == 0 && s[14], "R7 unloaded after last", s[26], 0);
      wr(4'h0, CTL | W1C);

      // R6: terminal-count interrupt disabled
      mon_clear(32'h500, 2, 0);
      wr(4'h0, CTL | (32'd1 << 23));
      wr(4'h8, 32'd8); wr(4'h4, 32'h500);
      wait_idle();
      rd(4'h0, s); chk(s[14] && !s[0] && !irq, "R6 tc without int pend", {s[14], s[0], irq}, 3'b100);
      wr(4'h0, CTL | W1C);

      // R10 R11: device request
      @(negedge clk); dev_req = 1'b1; @(negedge clk); dev_req = 1'b0;
      rd(4'h0, s); chk(s[0] && !s[14], "R10 device pend no tc", {s[0], s[14]}, 2'b10);
      chk(irq == 1, "R11 irq on device pend", irq, 1);
      wr(4'h0, CTL & ~(32'd1 << 4));
      chk(irq == 0, "R11 irq masked", irq, 0);
      wr(4'h0, CTL | W1C);
      chk(irq == 0, "R11 irq after clear", irq, 0);

      // R9: bus error aborts
      mon_clear(32'h600, 1, 0);
      err_mode = 1'b1;
      wr(4'h8, 32'd12); wr(4'h4, 32'h600);
      wait_idle();
      err_mode = 1'b0;
      rd(4'h0, s);
      chk(s[1] && !s[26] && beats == 1, "R9 error abort", {s[1], s[26], beats[3:0]}, 6'b10_0001);
      chk(irq == 1, "R11 irq on error", irq, 1);
      wr(4'h0, CTL | W1C);
      rd(4'h0, s); chk(!s[1] && !irq, "R8 error cleared", {s[1], irq}, 0);

      // R13: direction and active bit
      mon_clear(32'h700, 8, 1);
      wr(4'h0, CTL | (32'd1 << 8) | (32'd1 << 19));
      wr(4'h8, 32'd32); wr(4'h4, 32'h700);
      v = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk); rd(4'h0, s);
         if (s[25]) v = 1;
      end
      wait_idle();
      chk(v == 1, "R13 active bit seen", v, 1);
      chk(wr_bad == 0 && beats == 8, "R13 write direction", wr_bad, 0);
      wr(4'h0, CTL | W1C);

      // R5 R12: count enable off, then reset with a cycle outstanding
      mon_clear(32'h900, 0, 0);
      chk_addr = 1'b0;
      wr(4'h0, (CTL & ~(32'd1 << 13)) | (32'd2 << 18));
      wr(4'h8, 32'd8); wr(4'h4, 32'h900);
      repeat (20) @(negedge clk);
      rd(4'h8, v); chk(v == 8, "R5 count held when disabled", v, 8);
      rd(4'h4, v); chk(v > 32'h900, "R5 address still advances", v, 32'h904);
      ack_en = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 10; i++) begin
         if (mem_req && !mem_ack) break;
         @(negedge clk);
      end
      @(negedge clk);
      wr(4'h0, 32'd1 << 7);
      rd(4'h0, s); chk(s == 32'h404, "R12 drain visible", s, 32'h404);
      chk(mem_req == 1, "R12 request held", mem_req, 1);
      v = beats;
      ack_en = 1'b1;
      repeat (5) @(negedge clk);
      rd(4'h0, s); chk(s == 0 && !mem_req && !irq, "R12 cleared after drain", s, 0);
      chk(beats == v + 1, "R12 only the drained cycle", beats, v + 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule